// File: doc/BRIEF.md
# Trace-Cache Microcode Rebuild Engine

This block rebuilds wide horizontal microcode from a compact stream of commands instead of holding it in a ROM. A fetch/unpack stage upstream hands it one command per handshake. Each command has an opcode plus its operand fields. The engine keeps a parameterised set of small trace caches, each line as wide as one microcode word. It fills lines with full values and patches them by bit-delta copies. It then tells an external replay unit, one per cache, which entries to read and in what order. A line that is already held is never sent again: a replay list may name one entry many times, so a list of 0,1,2,0 needs only three fills.

The outputs are event ports, each valid for one cycle in the cycle after the command is accepted:
- a cache write port that shows every line the engine stores,
- a sequence load port toward the replay units,
- a redirect port that sends command fetch to a new address.

A STOP command parks the engine until a START arrives. A sequence aimed at a replay unit that is still busy is held off through the ready signal.

Top module: `ucode_rebuild_core`

## Requirements
- R1: A synchronous active-high reset clears every cache line to zero, drops all event outputs and their data fields to zero, sets every stored sequence length to MAXSEQ and leaves the engine running. A COPY from a never-written entry yields the mask itself.
- R2: Opcode codes are NOP=0, WRITE=1, SEQUENCE=2, START=3, JUMP=4, SEQLENGTH=5, STOP=6, COPY=7. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While running, ready is high for every opcode except a blocked SEQUENCE (R7).
- R3: An accepted WRITE stores `cmd_line` at entry `cmd_dst` of cache `cmd_cache`. In the next cycle `wr_en` has only bit `cmd_cache` set, with `wr_idx`=`cmd_dst` and `wr_data`=`cmd_line`.
- R4: An accepted COPY stores the `cmd_src` line of that cache, XOR `cmd_line` (the flip mask), into `cmd_dst`, and reports it on the write port as in R3. It reads the line as it stood before the command. Source equal to destination flips the bits in place.
- R5: An accepted SEQLENGTH stores `cmd_len` as the length for cache `cmd_cache`, clamped to MAXSEQ. It produces no event.
- R6: An accepted SEQUENCE pulses only bit `cmd_cache` of `seq_load` in the next cycle. `seq_len` carries that cache's stored length. `seq_idx` carries the `cmd_seq` list: slot p sits at bits [p*IW +: IW], and slots at or beyond the length read as zero.
- R7: While `seq_busy[cmd_cache]` is high, a SEQUENCE for that cache sees `cmd_ready` low. Sequences for other caches are not held.
- R8: An accepted JUMP pulses `jump_valid` for one cycle, with `jump_addr`=`cmd_addr` held until the next JUMP.
- R9: After a STOP is accepted, `cmd_ready` is low for every opcode except START. A START resumes normal acceptance.
- R10: An accepted NOP changes no cache line, no length and no output.
- R11: Event data fields (`wr_idx`, `wr_data`, `seq_len`, `seq_idx`, `jump_addr`) change only with their own event. At most one event fires per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode (R2 codes) |
| cmd_cache | input | CW | Target cache number |
| cmd_dst | input | IW | Destination entry (WRITE, COPY) |
| cmd_src | input | IW | Source entry (COPY) |
| cmd_line | input | LW | Line value (WRITE) or flip mask (COPY) |
| cmd_len | input | LENW | Sequence length (SEQLENGTH) |
| cmd_seq | input | MAXSEQ*IW | Entry index list (SEQUENCE) |
| cmd_addr | input | AW | Fetch redirect address (JUMP) |
| seq_busy | input | NC | Replay unit still running, one bit per cache |
| wr_en | output | NC | Cache write event, one bit per cache |
| wr_idx | output | IW | Entry written |
| wr_data | output | LW | Line value written |
| seq_load | output | NC | Sequence load event, one bit per cache |
| seq_len | output | LENW | Length of the loaded sequence |
| seq_idx | output | MAXSEQ*IW | Loaded index list, unused slots zero |
| jump_valid | output | 1 | Fetch redirect event |
| jump_addr | output | AW | Fetch redirect address |

## Verification
The hardest situations to reach are a held-off SEQUENCE while a replay unit is busy, and a command offered while the engine is stopped. In both, nothing visible happens, so only the ready signal shows that the command was held. The bench drives the busy inputs itself. It keeps a SEQUENCE for a busy cache on the port for several cycles, then offers one to the other cache in between. It also offers WRITE and NOP commands in the stopped state before sending START. Every one of those cycles is compared against the behavioural model's prediction of ready and of all event outputs.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WRITE    = 3'd1,
        OP_SEQUENCE = 3'd2,
        OP_START    = 3'd3,
        OP_JUMP     = 3'd4,
        OP_SEQLEN   = 3'd5,
        OP_STOP     = 3'd6,
        OP_COPY     = 3'd7
    } ucr_op_e;

    // One-hot action strobes for an accepted command
    typedef struct packed {
        logic wr;
        logic cp;
        logic sq;
        logic sl;
        logic jp;
        logic go;
        logic halt;
    } ucr_act_t;

    function automatic ucr_act_t ucr_decode(ucr_op_e op);
        ucr_act_t a;
        a = '0;
        case (op)
            OP_WRITE:    a.wr   = 1'b1;
            OP_COPY:     a.cp   = 1'b1;
            OP_SEQUENCE: a.sq   = 1'b1;
            OP_SEQLEN:   a.sl   = 1'b1;
            OP_JUMP:     a.jp   = 1'b1;
            OP_START:    a.go   = 1'b1;
            OP_STOP:     a.halt = 1'b1;
            default:     a      = '0;
        endcase
        return a;
    endfunction

    function automatic logic ucr_may_accept(ucr_op_e op, logic running, logic target_busy);
        if (!running)
            return op == OP_START;
        return !(op == OP_SEQUENCE && target_busy);
    endfunction

endpackage

// File: rtl/ucr_issue.sv
module ucr_issue
    import ucr_pkg::*;
#(
    parameter int NC = 2,
    parameter int CW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [CW-1:0] cmd_cache,
    input  logic [NC-1:0] seq_busy,
    output logic          cmd_ready,
    output ucr_act_t      act
);

    ucr_op_e op;
    logic    run_q;
    logic    tgt_busy;
    logic    fire;

    assign op        = ucr_op_e'(cmd_op);
    assign tgt_busy  = seq_busy[cmd_cache];
    assign cmd_ready = ucr_may_accept(op, run_q, tgt_busy);
    assign fire      = cmd_valid && cmd_ready;
    assign act       = fire ? ucr_decode(op) : '0;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 1'b1;
        else if (act.halt)
            run_q <= 1'b0;
        else if (act.go)
            run_q <= 1'b1;
    end

    AST_STOP_PARKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && op == OP_STOP) |=> (op == OP_START || !cmd_ready)); // R9

    AST_BUSY_HOLDS_SEQ: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEQUENCE && tgt_busy) |-> !cmd_ready); // R7

endmodule

// File: rtl/ucr_cache_bank.sv
module ucr_cache_bank
    import ucr_pkg::*;
#(
    parameter int NC    = 2,
    parameter int DEPTH = 8,
    parameter int LW    = 32,
    parameter int IW    = 3,
    parameter int CW    = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  ucr_act_t      act,
    input  logic [CW-1:0] cmd_cache,
    input  logic [IW-1:0] cmd_dst,
    input  logic [IW-1:0] cmd_src,
    input  logic [LW-1:0] cmd_line,
    output logic [NC-1:0] wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [LW-1:0] wr_data
);

    logic [LW-1:0] cand [NC];
    logic [NC-1:0] hit;

    for (genvar g = 0; g < NC; g++) begin : g_cache
        logic [LW-1:0] line_q [DEPTH];

        assign hit[g]  = (int'(cmd_cache) == g) && (act.wr || act.cp);
        assign cand[g] = act.cp ? (line_q[cmd_src] ^ cmd_line) : cmd_line;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++)
                    line_q[i] <= '0;
            end else if (hit[g]) begin
                line_q[cmd_dst] <= cand[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= '0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= hit;
            if (|hit) begin
                wr_idx  <= cmd_dst;
                wr_data <= cand[cmd_cache];
            end
        end
    end

    AST_ONE_CACHE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en)); // R11

    AST_WR_EVENT_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> $past(act.wr || act.cp)); // R3

endmodule

// File: rtl/ucr_seq_port.sv
module ucr_seq_port
    import ucr_pkg::*;
#(
    parameter int NC     = 2,
    parameter int MAXSEQ = 8,
    parameter int IW     = 3,
    parameter int CW     = 1,
    parameter int LENW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ucr_act_t             act,
    input  logic [CW-1:0]        cmd_cache,
    input  logic [LENW-1:0]      cmd_len,
    input  logic [MAXSEQ*IW-1:0] cmd_seq,
    output logic [NC-1:0]        seq_load,
    output logic [LENW-1:0]      seq_len,
    output logic [MAXSEQ*IW-1:0] seq_idx
);

    localparam logic [LENW-1:0] LEN_MAX = LENW'(MAXSEQ);

    logic [LENW-1:0]      len_q [NC];
    logic [LENW-1:0]      cur_len;
    logic [LENW-1:0]      len_clamped;
    logic [MAXSEQ*IW-1:0] trimmed;
    logic [NC-1:0]        load_vec;

    assign cur_len     = len_q[cmd_cache];
    assign len_clamped = (cmd_len > LEN_MAX) ? LEN_MAX : cmd_len;

    for (genvar p = 0; p < MAXSEQ; p++) begin : g_slot
        assign trimmed[p*IW +: IW] = (LENW'(p) < cur_len) ? cmd_seq[p*IW +: IW] : '0;
    end

    for (genvar g = 0; g < NC; g++) begin : g_len
        assign load_vec[g] = act.sq && (int'(cmd_cache) == g);

        always_ff @(posedge clk) begin
            if (rst)
                len_q[g] <= LEN_MAX;
            else if (act.sl && int'(cmd_cache) == g)
                len_q[g] <= len_clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_load <= '0;
            seq_len  <= '0;
            seq_idx  <= '0;
        end else begin
            seq_load <= load_vec;
            if (act.sq) begin
                seq_len <= cur_len;
                seq_idx <= trimmed;
            end
        end
    end

    AST_ONE_SEQ_LOAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(seq_load)); // R6

    AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (|seq_load) |-> (seq_len <= LEN_MAX)); // R5

endmodule

// File: rtl/ucode_rebuild_core.sv
module ucode_rebuild_core
    import ucr_pkg::*;
#(
    parameter int NC     = 2,
    parameter int DEPTH  = 8,
    parameter int LW     = 32,
    parameter int MAXSEQ = 8,
    parameter int AW     = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = (NC > 1) ? $clog2(NC) : 1,
    localparam int LENW  = $clog2(MAXSEQ + 1),
    localparam int SW    = MAXSEQ * IW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [2:0]      cmd_op,
    input  logic [CW-1:0]   cmd_cache,
    input  logic [IW-1:0]   cmd_dst,
    input  logic [IW-1:0]   cmd_src,
    input  logic [LW-1:0]   cmd_line,
    input  logic [LENW-1:0] cmd_len,
    input  logic [SW-1:0]   cmd_seq,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [NC-1:0]   seq_busy,
    output logic [NC-1:0]   wr_en,
    output logic [IW-1:0]   wr_idx,
    output logic [LW-1:0]   wr_data,
    output logic [NC-1:0]   seq_load,
    output logic [LENW-1:0] seq_len,
    output logic [SW-1:0]   seq_idx,
    output logic            jump_valid,
    output logic [AW-1:0]   jump_addr
);

    ucr_act_t act;

    ucr_issue #(.NC(NC), .CW(CW)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_cache (cmd_cache),
        .seq_busy  (seq_busy),
        .cmd_ready (cmd_ready),
        .act       (act)
    );

    ucr_cache_bank #(.NC(NC), .DEPTH(DEPTH), .LW(LW), .IW(IW), .CW(CW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .cmd_cache (cmd_cache),
        .cmd_dst   (cmd_dst),
        .cmd_src   (cmd_src),
        .cmd_line  (cmd_line),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    ucr_seq_port #(.NC(NC), .MAXSEQ(MAXSEQ), .IW(IW), .CW(CW), .LENW(LENW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .cmd_cache (cmd_cache),
        .cmd_len   (cmd_len),
        .cmd_seq   (cmd_seq),
        .seq_load  (seq_load),
        .seq_len   (seq_len),
        .seq_idx   (seq_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            jump_valid <= 1'b0;
            jump_addr  <= '0;
        end else begin
            jump_valid <= act.jp;
            if (act.jp)
                jump_addr <= cmd_addr;
        end
    end

    AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        ((seq_load & $past(seq_busy)) == '0)); // R7

    AST_JUMP_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        jump_valid |-> $past(cmd_valid && cmd_op == OP_JUMP)); // R8

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == OP_NOP)
            |=> (wr_en == '0 && seq_load == '0 && !jump_valid)); // R10

    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
        ($countones({wr_en, seq_load, jump_valid}) <= 1)); // R11

endmodule

// File: tb/ucode_rebuild_core_tb.sv
module ucode_rebuild_core_tb;
    import ucr_pkg::*;

    localparam int NC = 2, DEPTH = 8, LW = 32, MAXSEQ = 8, AW = 16;
    localparam int IW = 3, CW = 1, LENW = 4, SW = MAXSEQ * IW;

    logic            clk = 1'b0;
    logic            rst;
    logic            cmd_valid;
    logic            cmd_ready;
    logic [2:0]      cmd_op;
    logic [CW-1:0]   cmd_cache;
    logic [IW-1:0]   cmd_dst;
    logic [IW-1:0]   cmd_src;
    logic [LW-1:0]   cmd_line;
    logic [LENW-1:0] cmd_len;
    logic [SW-1:0]   cmd_seq;
    logic [AW-1:0]   cmd_addr;
    logic [NC-1:0]   seq_busy;
    logic [NC-1:0]   wr_en;
    logic [IW-1:0]   wr_idx;
    logic [LW-1:0]   wr_data;
    logic [NC-1:0]   seq_load;
    logic [LENW-1:0] seq_len;
    logic [SW-1:0]   seq_idx;
    logic            jump_valid;
    logic [AW-1:0]   jump_addr;

    always #4 clk = ~clk;

    ucode_rebuild_core #(.NC(NC), .DEPTH(DEPTH), .LW(LW), .MAXSEQ(MAXSEQ), .AW(AW)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_cache(cmd_cache), .cmd_dst(cmd_dst), .cmd_src(cmd_src),
        .cmd_line(cmd_line), .cmd_len(cmd_len), .cmd_seq(cmd_seq), .cmd_addr(cmd_addr),
        .seq_busy(seq_busy), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .seq_load(seq_load), .seq_len(seq_len), .seq_idx(seq_idx),
        .jump_valid(jump_valid), .jump_addr(jump_addr)
    );

    // Behavioural reference state
    logic [LW-1:0] m_line [NC][DEPTH];
    int            m_len [NC];
    bit            m_run;
    logic [NC-1:0] e_wr_en, e_seq_load;
    logic [IW-1:0] e_wr_idx;
    logic [LW-1:0] e_wr_data;
    logic [LENW-1:0] e_seq_len;
    logic [SW-1:0] e_seq_idx;
    logic          e_jv;
    logic [AW-1:0] e_ja;
    bit            took;
    int            nvec = 0;
    int            nbad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] pk(input int a0, a1, a2, a3, a4, a5, a6, a7);
        return {IW'(a7), IW'(a6), IW'(a5), IW'(a4), IW'(a3), IW'(a2), IW'(a1), IW'(a0)};
    endfunction

    task automatic cmp_outputs(input string tag);
        chk(wr_en === e_wr_en, tag, "wr_en", 64'(wr_en), 64'(e_wr_en));
        chk(wr_idx === e_wr_idx, tag, "wr_idx", 64'(wr_idx), 64'(e_wr_idx));
        chk(wr_data === e_wr_data, tag, "wr_data", 64'(wr_data), 64'(e_wr_data));
        chk(seq_load === e_seq_load, tag, "seq_load", 64'(seq_load), 64'(e_seq_load));
        chk(seq_len === e_seq_len, tag, "seq_len", 64'(seq_len), 64'(e_seq_len));
        chk(seq_idx === e_seq_idx, tag, "seq_idx", 64'(seq_idx), 64'(e_seq_idx));
        chk(jump_valid === e_jv, tag, "jump_valid", 64'(jump_valid), 64'(e_jv));
        chk(jump_addr === e_ja, tag, "jump_addr", 64'(jump_addr), 64'(e_ja));
    endtask

    // Inputs are already driven (just after a falling edge); predict and compare one cycle
    task automatic step();
        ucr_op_e op;
        bit      mready;
        string   rtag;
        string   otag;
        int      c;
        #1;
        op = ucr_op_e'(cmd_op);
        c  = int'(cmd_cache);
        mready = m_run ? !(op == OP_SEQUENCE && seq_busy[c]) : (op == OP_START);
        rtag = !m_run ? "R9" : (op == OP_SEQUENCE ? "R7" : "R2");
        chk(cmd_ready === mready, rtag, "cmd_ready", 64'(cmd_ready), 64'(mready));
        e_wr_en = '0; e_seq_load = '0; e_jv = 1'b0;
        otag = "R11";
        took = cmd_valid && mready;
        if (took) begin
            case (op)
                OP_WRITE: begin
                    m_line[c][cmd_dst] = cmd_line;
                    e_wr_en = NC'(1) << c; e_wr_idx = cmd_dst; e_wr_data = cmd_line;
                    otag = "R3";
                end
                OP_COPY: begin
                    e_wr_data = m_line[c][cmd_src] ^ cmd_line;
                    m_line[c][cmd_dst] = e_wr_data;
                    e_wr_en = NC'(1) << c; e_wr_idx = cmd_dst;
                    otag = "R4";
                end
                OP_SEQLEN: begin
                    m_len[c] = (int'(cmd_len) > MAXSEQ) ? MAXSEQ : int'(cmd_len);
                    otag = "R5";
                end
                OP_SEQUENCE: begin
                    e_seq_load = NC'(1) << c;
                    e_seq_len = LENW'(m_len[c]);
                    for (int p = 0; p < MAXSEQ; p++)
                        e_seq_idx[p*IW +: IW] = (p < m_len[c]) ? cmd_seq[p*IW +: IW] : '0;
                    otag = "R6";
                end
                OP_JUMP: begin e_jv = 1'b1; e_ja = cmd_addr; otag = "R8"; end
                OP_STOP: begin m_run = 1'b0; otag = "R9"; end
                OP_START: begin m_run = 1'b1; otag = "R9"; end
                default: otag = "R10";
            endcase
        end
        @(negedge clk);
        cmd_outputs_done: cmp_outputs(otag);
    endtask

    task automatic drive(input ucr_op_e op, input int c, input int d, input int s,
                         input logic [LW-1:0] line, input int len, input logic [SW-1:0] sq,
                         input int addr);
        cmd_valid = 1'b1; cmd_op = op; cmd_cache = CW'(c); cmd_dst = IW'(d);
        cmd_src = IW'(s); cmd_line = line; cmd_len = LENW'(len); cmd_seq = sq;
        cmd_addr = AW'(addr);
    endtask

    task automatic send(input ucr_op_e op, input int c, input int d, input int s,
                        input logic [LW-1:0] line, input int len, input logic [SW-1:0] sq,
                        input int addr);
        drive(op, c, d, s, line, len, sq, addr);
        do step(); while (!took);
        cmd_valid = 1'b0;
    endtask

    task automatic hold(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_cache = '0; cmd_dst = '0;
        cmd_src = '0; cmd_line = '0; cmd_len = '0; cmd_seq = '0; cmd_addr = '0;
        seq_busy = '0;
        for (int c = 0; c < NC; c++) begin
            m_len[c] = MAXSEQ;
            for (int i = 0; i < DEPTH; i++) m_line[c][i] = '0;
        end
        m_run = 1'b1;
        e_wr_en = '0; e_wr_idx = '0; e_wr_data = '0; e_seq_load = '0;
        e_seq_len = '0; e_seq_idx = '0; e_jv = 1'b0; e_ja = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_outputs("R1");                                   // R1 reset state
        hold(2);

        // R3 fills, then R4 copies reveal contents
        send(OP_WRITE, 0, 0, 0, 32'hDEAD_0001, 0, '0, 0);
        send(OP_WRITE, 0, 1, 0, 32'h0000_00F0, 0, '0, 0);
        send(OP_WRITE, 0, 2, 0, 32'h8000_0000, 0, '0, 0);
        send(OP_COPY,  0, 3, 0, 32'h0000_0003, 0, '0, 0);
        send(OP_COPY,  0, 1, 1, 32'h0000_0011, 0, '0, 0);   // R4 in place
        send(OP_COPY,  0, 1, 1, 32'h0000_0011, 0, '0, 0);   // R4 flips back
        send(OP_COPY,  0, 4, 1, 32'h0000_0000, 0, '0, 0);
        send(OP_WRITE, 1, 7, 0, 32'h1234_5678, 0, '0, 0);
        send(OP_COPY,  1, 0, 7, 32'hFFFF_0000, 0, '0, 0);
        send(OP_COPY,  1, 6, 5, 32'hA5A5_A5A5, 0, '0, 0);   // R1 unwritten source is zero
        send(OP_COPY,  0, 5, 7, 32'h0000_0000, 0, '0, 0);   // R1 cache 0 untouched by cache 1

        // R6 default length, R5 set/clamp/zero
        send(OP_SEQUENCE, 0, 0, 0, '0, 0, pk(0, 1, 2, 0, 3, 4, 1, 2), 0);
        send(OP_SEQLEN, 0, 0, 0, '0, 4, '0, 0);
        send(OP_SEQUENCE, 0, 0, 0, '0, 0, pk(0, 1, 2, 0, 7, 7, 7, 7), 0);
        send(OP_SEQLEN, 1, 0, 0, '0, 12, '0, 0);
        send(OP_SEQUENCE, 1, 0, 0, '0, 0, pk(7, 6, 5, 4, 3, 2, 1, 7), 0);
        send(OP_SEQLEN, 1, 0, 0, '0, 0, '0, 0);
        send(OP_SEQUENCE, 1, 0, 0, '0, 0, pk(5, 5, 5, 5, 5, 5, 5, 5), 0);
        send(OP_SEQLEN, 1, 0, 0, '0, 3, '0, 0);

        // R7 busy replay unit holds its sequence, the other cache proceeds
        seq_busy = 2'b10;
        drive(OP_SEQUENCE, 1, 0, 0, '0, 0, pk(1, 2, 3, 4, 5, 6, 7, 0), 0);
        hold(4);
        send(OP_SEQUENCE, 0, 0, 0, '0, 0, pk(3, 3, 2, 2, 1, 1, 0, 0), 0);
        drive(OP_SEQUENCE, 1, 0, 0, '0, 0, pk(1, 2, 3, 4, 5, 6, 7, 0), 0);
        hold(2);
        seq_busy = 2'b00;
        send(OP_SEQUENCE, 1, 0, 0, '0, 0, pk(1, 2, 3, 4, 5, 6, 7, 0), 0);

        // R8 redirect
        send(OP_JUMP, 0, 0, 0, '0, 0, '0, 16'h0A5C);
        hold(2);
        send(OP_JUMP, 1, 0, 0, '0, 0, '0, 16'hFFFE);

        // R10 NOP between events
        send(OP_NOP, 1, 3, 3, 32'hFFFF_FFFF, 5, '1, 16'h1111);
        send(OP_COPY, 0, 6, 3, 32'h0, 0, '0, 0);

        // R9 stopped state
        send(OP_STOP, 0, 0, 0, '0, 0, '0, 0);
        drive(OP_WRITE, 0, 3, 0, 32'h7777_7777, 0, '0, 0);
        hold(3);
        drive(OP_NOP, 0, 0, 0, '0, 0, '0, 0);
        hold(2);
        drive(OP_JUMP, 0, 0, 0, '0, 0, '0, 16'h2222);
        hold(2);
        send(OP_START, 0, 0, 0, '0, 0, '0, 0);
        send(OP_COPY, 0, 2, 3, 32'h0, 0, '0, 0);            // R9 entry 3 unchanged by held WRITE
        send(OP_WRITE, 0, 3, 0, 32'h7777_7777, 0, '0, 0);
        send(OP_COPY, 0, 4, 3, 32'h0000_0001, 0, '0, 0);
        hold(3);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule